// File: doc/BRIEF.md
# One-Time Write Protect Arbiter

This block sits between the serial front end of a small byte-wide nonvolatile store and its array controller, and decides whether each write is allowed. It watches the transaction events that the front end decodes: a control byte with its 4-bit access code and read/write bit, each buffered data byte with its target word address, and the stop condition. From these it produces the acknowledge decision for the control byte, the acknowledge for each received data byte, and a commit enable that tells the array controller whether that byte may actually be written.

Two protection sources are combined. A hardware protect pin blocks every array write while it is high. A one-time lock bit blocks only the lower half of the array, and once set it cannot be cleared by the functional reset, only by the power-on initialisation input. Software sets the lock by sending a write with the register access code while the pin is low. Software reads the lock state through the acknowledge: once the lock is set, control bytes that carry the register code are refused.

Top module: `otp_write_guard`

## Requirements
- R1: While `wp_pin` is high, every data byte of an array write session (code 4'b1010, rw = 0) gives `commit_en` = 0 and `data_ack` = 1, one cycle after `byte_valid`, whatever the lock state.
- R2: While `wp_pin` is low and `half_lock` is 1, an array write byte with address below 8'h80 gives `commit_en` = 0, and one at 8'h80 or above gives `commit_en` = 1.
- R3: While `wp_pin` is low and `half_lock` is 0, every array write byte gives `commit_en` = 1, for any address.
- R4: While `half_lock` is 1, a control byte with code 4'b0110 gives `ctl_ack` = 0 for both rw values, and the data bytes that follow give `data_ack` = 0 and `commit_en` = 0.
- R5: A register write session (code 4'b0110, rw = 0) opened while `half_lock` is 0 and `wp_pin` is low, with `wp_pin` still low at the stop, drives `half_lock` to 1 in the cycle after `stop_evt`; its data bytes are acknowledged and never committed.
- R6: With `wp_pin` high, a 4'b0110 write control byte while `half_lock` is 0 gives `ctl_ack` = 1, yet `half_lock` stays 0 after the stop.
- R7: A 4'b0110 read control byte while `half_lock` is 0 gives `ctl_ack` = 1 and leaves `half_lock` unchanged.
- R8: A 4'b1010 control byte gives `ctl_ack` = 1 for both rw values in any protection state; bytes in an array read session give `commit_en` = 0 and `data_ack` = 0.
- R9: `wcyc_start` pulses for one cycle, the cycle after `stop_evt`, when the stop closes an array write session that received at least one data byte (blocked or not) or an acknowledged register write session; after a read session or a refused control byte it stays 0.
- R10: Deasserting `rst_n` never clears `half_lock`; only `por_n` low clears it. After reset all other outputs are 0.
- R11: A control byte with any code other than 4'b1010 and 4'b0110 gives `ctl_ack` = 0, and its data bytes are neither acknowledged nor committed.
- R12: All outputs except `half_lock` are registered and appear in the cycle after the input event; `ctl_valid`, `byte_valid` and `stop_evt` are never asserted together, and `stop_evt` ends any session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous; leaves the lock untouched |
| por_n | input | 1 | Power-on initialisation, active low; the only way to clear the lock |
| wp_pin | input | 1 | Hardware protect pin, high blocks all array writes |
| ctl_valid | input | 1 | One-cycle pulse: control byte received |
| ctl_code | input | 4 | Access code of the control byte (1010 array, 0110 register) |
| ctl_rw | input | 1 | Read/write bit of the control byte, 1 = read |
| byte_valid | input | 1 | One-cycle pulse: a data byte has been buffered |
| byte_addr | input | ADDR_W | Word address that byte would be written to |
| stop_evt | input | 1 | One-cycle pulse: stop condition seen |
| ctl_ack | output | 1 | Acknowledge decision for the last control byte |
| data_ack | output | 1 | Acknowledge for the last data byte |
| commit_en | output | 1 | Last data byte may be written to the array |
| wcyc_start | output | 1 | One-cycle request to start the timed write cycle |
| half_lock | output | 1 | State of the one-time lower-half lock |

## Verification
The bench builds the block with its default parameters: an 8-bit word address with the protected region covering the lower 128 words, so both sides of the 7Fh/80h boundary and the first and last words are reached by directed bytes. A behavioural model tracks session, lock and pending write cycle with plain integers and is compared with all five outputs every cycle, through directed sequences for each protection combination and a long random mix of codes, pin changes, stops and power-on pulses that programs and clears the lock many times.

// File: rtl/otpg_pkg.sv
package otpg_pkg;

  typedef enum logic [2:0] {
    SES_IDLE   = 3'd0,
    SES_ARR_WR = 3'd1,
    SES_ARR_RD = 3'd2,
    SES_REG_WR = 3'd3,
    SES_REG_RD = 3'd4
  } ses_e;

  // Whether a control byte earns an acknowledge.
  function automatic logic ctl_accept(input logic [3:0] code,
                                      input logic       lock,
                                      input logic [3:0] arr_code,
                                      input logic [3:0] reg_code);
    if (code == arr_code) return 1'b1;
    if (code == reg_code) return !lock;
    return 1'b0;
  endfunction

  // Whether an array byte may be committed.
  function automatic logic write_ok(input logic wp,
                                    input logic lock,
                                    input logic in_low);
    return !wp && !(lock && in_low);
  endfunction

  // Whether a stop closes a session that needs the timed write cycle.
  function automatic logic needs_cycle(input ses_e ses, input logic wrote);
    return (ses == SES_REG_WR) || ((ses == SES_ARR_WR) && wrote);
  endfunction

endpackage

// File: rtl/otpg_lock_cell.sv
module otpg_lock_cell (
  input  logic clk,
  input  logic por_n,
  input  logic set_req,
  output logic lock_q
);
  // Sticky bit: only the power-on input clears it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       lock_q <= 1'b0;
    else if (set_req) lock_q <= 1'b1;
  end
endmodule

// File: rtl/otpg_session.sv
module otpg_session
  import otpg_pkg::*;
#(
  parameter logic [3:0] ARR_CODE = 4'b1010,
  parameter logic [3:0] REG_CODE = 4'b0110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_pin,
  input  logic       lock,
  input  logic       ctl_valid,
  input  logic [3:0] ctl_code,
  input  logic       ctl_rw,
  input  logic       byte_valid,
  input  logic       stop_evt,
  output ses_e       ses,
  output logic       ctl_ack_q,
  output logic       wcyc_q,
  output logic       prog_req
);
  logic wrote_q;
  logic armed_q;
  logic accept;
  ses_e ses_next;

  assign accept = ctl_accept(ctl_code, lock, ARR_CODE, REG_CODE);

  always_comb begin
    ses_next = SES_IDLE;
    if (accept) begin
      if (ctl_code == ARR_CODE) ses_next = ctl_rw ? SES_ARR_RD : SES_ARR_WR;
      else                      ses_next = ctl_rw ? SES_REG_RD : SES_REG_WR;
    end
  end

  // Legal program: register write opened with pin low, pin still low at stop.
  assign prog_req = stop_evt && (ses == SES_REG_WR) && armed_q && !wp_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ses       <= SES_IDLE;
      wrote_q   <= 1'b0;
      armed_q   <= 1'b0;
      ctl_ack_q <= 1'b0;
      wcyc_q    <= 1'b0;
    end else begin
      ctl_ack_q <= 1'b0;
      wcyc_q    <= 1'b0;
      if (stop_evt) begin
        wcyc_q  <= needs_cycle(ses, wrote_q);
        ses     <= SES_IDLE;
        wrote_q <= 1'b0;
        armed_q <= 1'b0;
      end else if (ctl_valid) begin
        ctl_ack_q <= accept;
        ses       <= ses_next;
        wrote_q   <= 1'b0;
        armed_q   <= (ses_next == SES_REG_WR) && !wp_pin;
      end else if (byte_valid && (ses == SES_ARR_WR)) begin
        wrote_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/otpg_commit_gate.sv
module otpg_commit_gate
  import otpg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LOW_WORDS = 2 ** (ADDR_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              lock,
  input  ses_e              ses,
  input  logic              byte_valid,
  input  logic [ADDR_W-1:0] byte_addr,
  output logic              commit_q,
  output logic              dack_q
);
  localparam logic [ADDR_W:0] LOW_LIM = (ADDR_W + 1)'(LOW_WORDS);

  function automatic logic in_low_region(input logic [ADDR_W-1:0] a);
    return {1'b0, a} < LOW_LIM;
  endfunction

  logic low_hit;
  logic allow;
  logic takes_data;

  assign low_hit    = in_low_region(byte_addr);
  assign allow      = write_ok(wp_pin, lock, low_hit);
  assign takes_data = (ses == SES_ARR_WR) || (ses == SES_REG_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      dack_q   <= 1'b0;
    end else begin
      commit_q <= byte_valid && (ses == SES_ARR_WR) && allow;
      dack_q   <= byte_valid && takes_data;
    end
  end
endmodule

// File: rtl/otp_write_guard.sv
module otp_write_guard
  import otpg_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         LOW_WORDS = 2 ** (ADDR_W - 1),
  parameter logic [3:0] ARR_CODE  = 4'b1010,
  parameter logic [3:0] REG_CODE  = 4'b0110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wp_pin,
  input  logic              ctl_valid,
  input  logic [3:0]        ctl_code,
  input  logic              ctl_rw,
  input  logic              byte_valid,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              stop_evt,
  output logic              ctl_ack,
  output logic              data_ack,
  output logic              commit_en,
  output logic              wcyc_start,
  output logic              half_lock
);
  ses_e ses;
  logic prog_req;

  otpg_lock_cell u_lock (
    .clk     (clk),
    .por_n   (por_n),
    .set_req (prog_req),
    .lock_q  (half_lock)
  );

  otpg_session #(
    .ARR_CODE (ARR_CODE),
    .REG_CODE (REG_CODE)
  ) u_ses (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_pin     (wp_pin),
    .lock       (half_lock),
    .ctl_valid  (ctl_valid),
    .ctl_code   (ctl_code),
    .ctl_rw     (ctl_rw),
    .byte_valid (byte_valid),
    .stop_evt   (stop_evt),
    .ses        (ses),
    .ctl_ack_q  (ctl_ack),
    .wcyc_q     (wcyc_start),
    .prog_req   (prog_req)
  );

  otpg_commit_gate #(
    .ADDR_W    (ADDR_W),
    .LOW_WORDS (LOW_WORDS)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_pin     (wp_pin),
    .lock       (half_lock),
    .ses        (ses),
    .byte_valid (byte_valid),
    .byte_addr  (byte_addr),
    .commit_q   (commit_en),
    .dack_q     (data_ack)
  );
endmodule

// File: rtl/otpg_checker.sv
module otpg_checker #(
  parameter int         ADDR_W    = 8,
  parameter int         LOW_WORDS = 2 ** (ADDR_W - 1),
  parameter logic [3:0] REG_CODE  = 4'b0110
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic              wp_pin,
  input logic              ctl_valid,
  input logic [3:0]        ctl_code,
  input logic              byte_valid,
  input logic [ADDR_W-1:0] byte_addr,
  input logic              stop_evt,
  input logic              ctl_ack,
  input logic              data_ack,
  input logic              commit_en,
  input logic              wcyc_start,
  input logic              half_lock
);
  localparam logic [ADDR_W:0] LOW_LIM = (ADDR_W + 1)'(LOW_WORDS);

  AST_PIN_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    commit_en |-> !$past(wp_pin)); // R1

  AST_LOW_HALF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ($past(half_lock) && ({1'b0, $past(byte_addr)} < LOW_LIM)) |-> !commit_en); // R2

  AST_LOCKED_REG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ctl_ack |-> !($past(half_lock) && ($past(ctl_code) == REG_CODE))); // R4

  AST_LOCK_SET_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(half_lock) |-> ($past(stop_evt) && !$past(wp_pin))); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    !$fell(half_lock)); // R10

  AST_CYCLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wcyc_start |-> $past(stop_evt)); // R9

  AST_CYCLE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wcyc_start |=> !wcyc_start); // R9

  AST_ACK_FOLLOWS_CTL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ctl_ack |-> $past(ctl_valid)); // R12

  AST_BYTE_OUTS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (commit_en || data_ack) |-> $past(byte_valid)); // R12

  AST_COMMIT_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    commit_en |-> data_ack); // R8
endmodule

bind otp_write_guard otpg_checker #(
  .ADDR_W    (ADDR_W),
  .LOW_WORDS (LOW_WORDS),
  .REG_CODE  (REG_CODE)
) u_chk (.*);

// File: tb/sim_otp_write_guard.sv
`timescale 1ns/1ps
module sim_otp_write_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_n = 1'b0;
  logic       wp_pin = 1'b0;
  logic       ctl_valid = 1'b0;
  logic [3:0] ctl_code = 4'h0;
  logic       ctl_rw = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_addr = 8'h00;
  logic       stop_evt = 1'b0;
  logic       ctl_ack, data_ack, commit_en, wcyc_start, half_lock;

  always #10 clk = ~clk; // 50 MHz

  otp_write_guard u0 (.*);

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    cmp_on = 0;
  bit    done = 0;
  string cur_req = "R10";

  // Behavioural reference: 0 idle, 1 array write, 2 array read, 3 reg write, 4 reg read
  int m_ses = 0;
  bit m_wrote = 0, m_armed = 0, m_lock = 0;
  bit e_ack = 0, e_dack = 0, e_commit = 0, e_wcyc = 0;

  always @(posedge clk) begin
    bit set_now;
    set_now = 0;
    if (!por_n) m_lock = 0;
    if (!rst_n) begin
      m_ses = 0; m_wrote = 0; m_armed = 0;
      e_ack = 0; e_dack = 0; e_commit = 0; e_wcyc = 0;
    end else begin
      e_ack  = 0;
      e_wcyc = 0;
      e_dack = byte_valid && (m_ses == 1 || m_ses == 3);
      e_commit = byte_valid && m_ses == 1 && !wp_pin && !(m_lock && byte_addr < 128);
      if (stop_evt) begin
        e_wcyc = (m_ses == 3) || (m_ses == 1 && m_wrote);
        set_now = (m_ses == 3) && m_armed && !wp_pin;
        m_ses = 0; m_wrote = 0; m_armed = 0;
      end else if (ctl_valid) begin
        m_wrote = 0;
        if (ctl_code == 4'b1010) begin
          e_ack = 1; m_ses = ctl_rw ? 2 : 1;
        end else if (ctl_code == 4'b0110 && !m_lock) begin
          e_ack = 1; m_ses = ctl_rw ? 4 : 3;
        end else begin
          m_ses = 0;
        end
        m_armed = (m_ses == 3) && !wp_pin;
      end else if (byte_valid && m_ses == 1) begin
        m_wrote = 1;
      end
      if (set_now && por_n) m_lock = 1;
    end
  end

  task automatic cmp1(input bit got, input bit exp, input string what, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      cmp1(ctl_ack,    e_ack,    "model ctl_ack",    cur_req);
      cmp1(data_ack,   e_dack,   "model data_ack",   cur_req);
      cmp1(commit_en,  e_commit, "model commit_en",  cur_req);
      cmp1(wcyc_start, e_wcyc,   "model wcyc_start", cur_req);
      cmp1(half_lock,  m_lock,   "model half_lock",  cur_req);
    end
  end

  task automatic ctl(input logic [3:0] code, input logic rw);
    @(negedge clk); ctl_valid = 1; ctl_code = code; ctl_rw = rw;
    @(negedge clk); ctl_valid = 0;
  endtask

  task automatic dbyte(input logic [7:0] a);
    @(negedge clk); byte_valid = 1; byte_addr = a;
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic stp();
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    cmp_on = 1;
    @(negedge clk); por_n = 1;
    @(negedge clk); rst_n = 1;
    idle(1);
    // R10 reset state
    cmp1(half_lock, 0, "lock after power-on", "R10");
    cmp1(ctl_ack | data_ack | commit_en | wcyc_start, 0, "outputs after reset", "R10");

    // R3 unlocked, pin low: all addresses commit
    cur_req = "R3";
    wp_pin = 0;
    ctl(4'b1010, 0); cmp1(ctl_ack, 1, "array write ack", "R3");
    dbyte(8'h10); cmp1(commit_en, 1, "commit 10h", "R3");
    dbyte(8'h00); cmp1(commit_en, 1, "commit 00h", "R3");
    dbyte(8'h90); cmp1(commit_en, 1, "commit 90h", "R3");
    stp(); cmp1(wcyc_start, 1, "write cycle after stop", "R9");
    idle(1); cmp1(wcyc_start, 0, "write cycle one shot", "R9");

    // R8 array read
    cur_req = "R8";
    ctl(4'b1010, 1); cmp1(ctl_ack, 1, "array read ack", "R8");
    dbyte(8'h05); cmp1(commit_en, 0, "read no commit", "R8");
    cmp1(data_ack, 0, "read no data ack", "R8");
    stp(); cmp1(wcyc_start, 0, "no cycle after read", "R9");

    // R7 register status read, unlocked
    cur_req = "R7";
    ctl(4'b0110, 1); cmp1(ctl_ack, 1, "reg read ack unlocked", "R7");
    stp(); idle(1); cmp1(half_lock, 0, "lock unchanged by read", "R7");

    // R6 register write with pin high
    cur_req = "R6";
    wp_pin = 1;
    ctl(4'b0110, 0); cmp1(ctl_ack, 1, "reg write ack pin high", "R6");
    dbyte(8'h33); cmp1(data_ack, 1, "reg data ack", "R6");
    cmp1(commit_en, 0, "reg data not committed", "R6");
    stp(); cmp1(wcyc_start, 1, "cycle after reg write", "R9");
    idle(1); cmp1(half_lock, 0, "lock not set pin high", "R6");

    // R1 pin high blocks array
    cur_req = "R1";
    ctl(4'b1010, 0);
    dbyte(8'h90); cmp1(commit_en, 0, "pin high block 90h", "R1");
    cmp1(data_ack, 1, "blocked byte still acked", "R1");
    dbyte(8'h01); cmp1(commit_en, 0, "pin high block 01h", "R1");
    stp(); cmp1(wcyc_start, 1, "cycle after blocked write", "R9");

    // R5 program the lock
    cur_req = "R5";
    wp_pin = 0;
    ctl(4'b0110, 0); cmp1(ctl_ack, 1, "reg write ack", "R5");
    dbyte(8'hAA); cmp1(commit_en, 0, "reg data not committed", "R5");
    cmp1(half_lock, 0, "lock before stop", "R5");
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
    cmp1(half_lock, 1, "lock set after stop", "R5");

    // R4 locked: register code refused
    cur_req = "R4";
    ctl(4'b0110, 0); cmp1(ctl_ack, 0, "reg write refused", "R4");
    dbyte(8'h90); cmp1(data_ack, 0, "no data ack refused", "R4");
    cmp1(commit_en, 0, "no commit refused", "R4");
    ctl(4'b0110, 1); cmp1(ctl_ack, 0, "reg read refused", "R4");
    stp(); cmp1(wcyc_start, 0, "no cycle after refused", "R9");

    // R2 locked, pin low: lower half blocked
    cur_req = "R2";
    ctl(4'b1010, 0); cmp1(ctl_ack, 1, "array ack locked", "R8");
    dbyte(8'h7F); cmp1(commit_en, 0, "block 7Fh", "R2");
    dbyte(8'h80); cmp1(commit_en, 1, "allow 80h", "R2");
    dbyte(8'h00); cmp1(commit_en, 0, "block 00h", "R2");
    dbyte(8'hFF); cmp1(commit_en, 1, "allow FFh", "R2");
    stp(); cmp1(wcyc_start, 1, "cycle after split write", "R9");

    // R9 write session with no data bytes
    cur_req = "R9";
    ctl(4'b1010, 0); stp(); cmp1(wcyc_start, 0, "no cycle without data", "R9");

    // R11 unknown code
    cur_req = "R11";
    ctl(4'b1111, 0); cmp1(ctl_ack, 0, "unknown code refused", "R11");
    dbyte(8'h90); cmp1(data_ack, 0, "no ack unknown", "R11");
    cmp1(commit_en, 0, "no commit unknown", "R11");
    stp();

    // R12 new control byte replaces the session
    cur_req = "R12";
    ctl(4'b1010, 0); ctl(4'b1010, 1);
    dbyte(8'h90); cmp1(data_ack, 0, "restart to read", "R12");

    // R10 functional reset keeps lock, power-on clears it
    cur_req = "R10";
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    idle(1); cmp1(half_lock, 1, "lock survives rst_n", "R10");
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    idle(1); cmp1(half_lock, 0, "lock cleared by por_n", "R10");

    // Random mix against the model
    cur_req = "R1/R2/R5/R9 random";
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r < 4) begin
        int c;
        c = $urandom_range(0, 3);
        ctl(c == 0 ? 4'b0110 : (c == 3 ? 4'b0011 : 4'b1010), 1'($urandom_range(0, 1)));
      end else if (r < 12) dbyte(8'($urandom_range(0, 255)));
      else if (r < 15) stp();
      else if (r < 17) begin @(negedge clk); wp_pin = 1'($urandom_range(0, 1)); end
      else if (r == 17) begin @(negedge clk); por_n = 0; @(negedge clk); por_n = 1; end
      else idle(1);
    end
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule